// File: doc/BRIEF.md
# Three-Channel Compare/Capture Event Flags

This block is a three-channel timer. Each channel, named U, V and W, has a 16-bit free-running counter and a general register. A two-bit mode field per channel makes the general register act as an output-compare value, as a capture register loaded on a rising or on a falling input edge, or as a pulse-width register. In pulse-width mode the counter restarts on the rising edge and is latched on the falling edge. Each channel has one external input pin, which passes through a two-flop synchronizer and then an edge detector.

A status register holds one event flag per channel. A flag is set whenever its channel's event fires, whatever the mode. Software clears a flag only with a handshake: it must read the status register while the flag is 1, and then write 0 to that bit. Each bit keeps its own armed latch. A status read loads the latch with the flag's current value, and any status write empties it. The bus is a plain register interface with a one-cycle read strobe and a one-cycle write strobe. Read data is combinational from the address.

Register map (address: content): 0 status; 1 mode; 2, 3, 4 general registers U, V, W; 5, 6, 7 counters U, V, W (read-only).

Top module: `tcf_event_timer`

## Requirements
- R1: After reset, status reads 0, the mode register reads 0, and every general register reads 16'hFFFF.
- R2: Status bits 15..3 always read 0, and writing ones to them changes nothing.
- R3: Mode 00 (compare) is held in mode bits [5:4] for U, [3:2] for V and [1:0] for W. In this mode the flag is set on the clock edge at which the counter equals the general register. The flag bits are U = bit 2, V = bit 1 and W = bit 0.
- R4: In mode 01 a rising edge of the pin, and in mode 10 a falling edge, copies the counter into the general register and sets the flag. If the pin changes before clock edge k, the copy happens at edge k+2 and stores the count held just before that edge. An edge of the other polarity does nothing.
- R5: In mode 11 a rising edge of the pin clears the counter, and a falling edge captures the counter and sets the flag. A pulse that is high for P clock cycles stores P-1.
- R6: Writing 1 to a flag bit has no effect. Writing 0 clears the flag only if the last status read returned 1 for that bit.
- R7: Any status write disarms every bit. A later 0 write with no read in between does not clear the flag.
- R8: A status read that returns 0 for a bit leaves that bit disarmed, even if the flag sets afterwards.
- R9: If a set event and a valid clearing write fall on the same edge, the flag stays 1.
- R10: Counters increment every cycle and wrap from 16'hFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe; arms the flag latches when the address is the status register |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| pin_i | input | 3 | External inputs, bit 0 = U, bit 1 = V, bit 2 = W |

## Verification
A capture started by a pin change before edge k lands at edge k+2. The bench therefore reads the status once between edges k+1 and k+2, where it expects 0, and once after k+2, where it expects 1. It also checks the captured value against a counter read taken just before edge k, plus two. A compare flag sets at the edge where the counter reaches the programmed value. The bench samples ten cycles before that edge and two cycles after it. Reads are combinational and are sampled one nanosecond after the falling edge. A clearing write takes effect at the next rising edge, and the bench reads it back on the following cycle. The set-over-clear case places the write on exactly edge k+2 of a capture.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [1:0] {
    MODE_CMP      = 2'b00,
    MODE_CAP_RISE = 2'b01,
    MODE_CAP_FALL = 2'b10,
    MODE_PULSE    = 2'b11
  } mode_e;

  localparam int unsigned A_STAT  = 0;
  localparam int unsigned A_MODE  = 1;
  localparam int unsigned GR_BASE = 2;
endpackage

// File: rtl/tcf_sync_edge.sv
module tcf_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tcf_channel.sv
module tcf_channel import tcf_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             gr_we_i,
  input  logic [CNT_W-1:0] gr_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] gr_o,
  output logic             cap_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q, gr_q;
  logic             cnt_clr, match;

  always_comb begin
    cap_o   = ((mode_i == MODE_CAP_RISE) && rise_i) ||
              ((mode_i == MODE_CAP_FALL) && fall_i) ||
              ((mode_i == MODE_PULSE)    && fall_i);
    cnt_clr = (mode_i == MODE_PULSE) && rise_i;
    match   = (mode_i == MODE_CMP) && (cnt_q == gr_q);
    evt_o   = cap_o | match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      gr_q  <= '1;  // all ones: no compare hit straight out of reset
    end else begin
      cnt_q <= cnt_clr ? '0 : cnt_q + 1'b1;
      if (cap_o)        gr_q <= cnt_q;
      else if (gr_we_i) gr_q <= gr_wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign gr_o  = gr_q;
endmodule

// File: rtl/tcf_flag_bank.sv
module tcf_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_stb_i,
  input  logic         wr_stb_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, arm_q, clr;

  assign clr = {N{wr_stb_i}} & arm_q & ~wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr);  // set beats clear
      if (wr_stb_i)      arm_q <= '0;
      else if (rd_stb_i) arm_q <= flag_q;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tcf_event_timer.sv
module tcf_event_timer import tcf_pkg::*; #(
  parameter int unsigned N_CH        = 3,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_BASE   = GR_BASE + N_CH,
  localparam int unsigned AW         = $clog2(CNT_BASE + N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [N_CH-1:0]  pin_i
);
  localparam int unsigned MW = 2 * N_CH;

  logic [MW-1:0]                 mode_q;
  logic [N_CH-1:0][CNT_W-1:0]    cnt_w, gr_w;
  logic [N_CH-1:0]               rise_w, fall_w, cap_w, evt_w;
  logic [N_CH-1:0]               set_vec, flag_w;
  logic                          stat_sel, mode_sel;

  assign stat_sel = (addr_i == AW'(A_STAT));
  assign mode_sel = (addr_i == AW'(A_MODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mode_q <= '0;
    else if (wr_i && mode_sel)  mode_q <= wdata_i[MW-1:0];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int unsigned FB = N_CH - 1 - g;  // channel 0 sits in the top flag bit

    tcf_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[g]),
      .rise_o (rise_w[g]),
      .fall_o (fall_w[g])
    );

    tcf_channel #(.CNT_W(CNT_W)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (mode_e'(mode_q[2*FB +: 2])),
      .rise_i     (rise_w[g]),
      .fall_i     (fall_w[g]),
      .gr_we_i    (wr_i && (addr_i == AW'(GR_BASE + g))),
      .gr_wdata_i (wdata_i),
      .cnt_o      (cnt_w[g]),
      .gr_o       (gr_w[g]),
      .cap_o      (cap_w[g]),
      .evt_o      (evt_w[g])
    );

    assign set_vec[FB] = evt_w[g];
  end

  tcf_flag_bank #(.N(N_CH)) i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .rd_stb_i (rd_i && stat_sel),
    .wr_stb_i (wr_i && stat_sel),
    .wdata_i  (wdata_i[N_CH-1:0]),
    .flag_o   (flag_w)
  );

  always_comb begin
    rdata_o = '0;
    if (stat_sel) rdata_o[N_CH-1:0] = flag_w;
    if (mode_sel) rdata_o[MW-1:0]   = mode_q;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == AW'(GR_BASE + i))  rdata_o = gr_w[i];
      if (addr_i == AW'(CNT_BASE + i)) rdata_o = cnt_w[i];
    end
  end
endmodule

// File: rtl/tcf_event_timer_chk.sv
module tcf_event_timer_chk import tcf_pkg::*; #(
  parameter int unsigned N_CH  = 3,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_i,
  input logic [AW-1:0]             addr_i,
  input logic [CNT_W-1:0]          wdata_i,
  input logic [CNT_W-1:0]          rdata_o,
  input logic [2*N_CH-1:0]         mode_i,
  input logic [N_CH-1:0]           flag_i,
  input logic [N_CH-1:0]           set_i,
  input logic [N_CH-1:0]           cap_i,
  input logic [N_CH-1:0][CNT_W-1:0] cnt_i,
  input logic [N_CH-1:0][CNT_W-1:0] gr_i
);
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(A_STAT)) |-> (rdata_o[CNT_W-1:N_CH] == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    localparam int unsigned FB = N_CH - 1 - c;

    p_cmp_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i[2*FB +: 2] == 2'b00) && (cnt_i[c] == gr_i[c])) |=> flag_i[FB]);

    p_capture_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_i[c] |=> (gr_i[c] == $past(cnt_i[c])));

    p_clear_by_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_i[FB]) |-> $past(wr_i && (addr_i == AW'(A_STAT)) && !wdata_i[FB]));

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[FB] |=> flag_i[FB]);

    p_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[c] == {CNT_W{1'b1}}) |=> (cnt_i[c] == '0));
  end
endmodule

bind tcf_event_timer tcf_event_timer_chk #(
  .N_CH  (N_CH),
  .CNT_W (CNT_W),
  .AW    (AW)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .mode_i  (mode_q),
  .flag_i  (flag_w),
  .set_i   (set_vec),
  .cap_i   (cap_w),
  .cnt_i   (cnt_w),
  .gr_i    (gr_w)
);

// File: tb/test_tcf_event_timer.sv
module test_tcf_event_timer;
  localparam int AW = 3;
  localparam int CW = 16;

  logic          clk = 1'b0, rst_n = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0, rdata;
  logic [2:0]    pin = '0;
  int            errors = 0, checks = 0;

  always #4 clk = ~clk;

  tcf_event_timer i_tcf_event_timer (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin)
  );

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [CW-1:0] d;
    bus_rd(0, d); check("R1 status", d, 16'h0000);
    bus_rd(1, d); check("R1 mode", d, 16'h0000);
    bus_rd(2, d); check("R1 gr U", d, 16'hFFFF);
  endtask

  task automatic t_cap_rise();  // U, mode 01
    logic [CW-1:0] c, d;
    @(negedge clk); pin[0] = 1'b1; rd = 1'b1; addr = 3'd5;
    #1 c = rdata;
    @(posedge clk); #1 rd = 1'b0;  // edge k
    @(posedge clk);                // edge k+1
    bus_rd(0, d); check("R4 U flag before k+2", {15'd0, d[2]}, 16'd0);
    bus_rd(0, d); check("R4 U flag after k+2", {15'd0, d[2]}, 16'd1);
    bus_rd(2, d); check("R4 U captured count", d, c + 16'd2);
  endtask

  task automatic t_cap_fall();  // W, mode 10
    logic [CW-1:0] c, d;
    @(negedge clk); pin[2] = 1'b1;
    repeat (5) @(posedge clk);
    bus_rd(0, d); check("R4 W rise ignored", {15'd0, d[0]}, 16'd0);
    @(negedge clk); pin[2] = 1'b0; rd = 1'b1; addr = 3'd7;
    #1 c = rdata;
    @(posedge clk); #1 rd = 1'b0;
    @(posedge clk);
    bus_rd(0, d); check("R4 W flag before k+2", {15'd0, d[0]}, 16'd0);
    bus_rd(0, d); check("R4 W flag after k+2", {15'd0, d[0]}, 16'd1);
    bus_rd(4, d); check("R4 W captured count", d, c + 16'd2);
  endtask

  task automatic pulse_v(input int p);
    @(negedge clk); pin[1] = 1'b1;
    repeat (p) @(posedge clk);
    @(negedge clk); pin[1] = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_pulse_width();  // V, mode 11
    logic [CW-1:0] d;
    pulse_v(40);
    bus_rd(3, d); check("R5 V width", d, 16'd39);
    bus_rd(0, d); check("R5 V flag", {15'd0, d[1]}, 16'd1);
  endtask

  task automatic t_clear_protocol();
    logic [CW-1:0] d;
    bus_wr(0, 16'hFFFF);
    bus_rd(0, d); check("R2 R6 write ones ignored", d, 16'h0007);
    bus_wr(0, 16'hFFFF);
    bus_wr(0, 16'h0000);
    bus_rd(0, d); check("R7 write disarms", d, 16'h0007);
    bus_wr(0, 16'h0000);
    bus_rd(0, d); check("R6 read then write 0 clears", d, 16'h0000);
  endtask

  task automatic t_zero_read_no_arm();
    logic [CW-1:0] d;
    bus_rd(0, d);
    pulse_v(10);
    bus_wr(0, 16'h0000);
    bus_rd(0, d); check("R8 zero read does not arm", d, 16'h0002);
  endtask

  task automatic t_set_wins();
    logic [CW-1:0] d;
    @(negedge clk); pin[0] = 1'b0; repeat (4) @(posedge clk);
    @(negedge clk); pin[0] = 1'b1; repeat (4) @(posedge clk);
    @(negedge clk); pin[0] = 1'b0; repeat (4) @(posedge clk);
    bus_rd(0, d);                  // arms U and V
    @(negedge clk); pin[0] = 1'b1;
    @(posedge clk);                // k
    @(posedge clk);                // k+1
    bus_wr(0, 16'h0000);           // lands on k+2 with the capture
    bus_rd(0, d); check("R9 set beats clear", d, 16'h0004);
  endtask

  task automatic t_compare();  // U, mode 00
    logic [CW-1:0] c, d;
    bus_rd(0, d);
    bus_wr(0, 16'h0000);
    bus_wr(1, 16'h000E);
    bus_rd(5, c);
    bus_wr(2, c + 16'd20);
    repeat (10) @(posedge clk);
    bus_rd(0, d); check("R3 no flag before match", {15'd0, d[2]}, 16'd0);
    repeat (10) @(posedge clk);
    bus_rd(0, d); check("R3 flag after match", {15'd0, d[2]}, 16'd1);
  endtask

  task automatic t_wrap();
    logic [CW-1:0] c, d;
    bus_rd(7, c);
    repeat (65535) @(posedge clk);
    bus_rd(7, d); check("R10 counter wraps", d, c);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    bus_wr(1, 16'h001E);  // U=01, V=11, W=10
    t_cap_rise();
    t_cap_fall();
    t_pulse_width();
    t_clear_protocol();
    t_zero_read_no_arm();
    t_set_wins();
    t_compare();
    t_wrap();
    summary();
    $finish;
  end
endmodule